// File: doc/BRIEF.md
# UART Bypass Pin Router

This block decides where a device's four UART signals meet the outside world. After reset the internal UART transmit and request-to-send lines drive the host-facing pads, and the host-facing receive and clear-to-send pads feed the internal UART. While reset is held, every pad output that the block controls is released to high impedance. This lets other devices share the host UART wires during that time.

A single-cycle command pulse switches the block into a bypass state that cannot be undone. In that state the host-facing pads are bridged through the block onto four spare general-purpose pins, named here PIO4 to PIO7 and carried on `gpio_*[0]` to `gpio_*[3]`. A second device on those pins can then talk to the host. The internal UART sees idle-high inputs, and a deep-sleep flag is raised and held. Only a reset brings the default routing back.

Top module: `uart_bypass_router`

## Requirements
- R1: While `rst` is high, `host_tx_oe`, `host_rts_oe` and all four bits of `gpio_oe` are 0, `deep_sleep` is 0, and `core_rx_o` and `core_cts_o` are 1.
- R2: In host routing with `rst` low, `host_tx_o` follows `core_tx_i`, `host_rts_o` follows `core_rts_i`, both host output enables are 1, `core_rx_o` follows `host_rx_i`, `core_cts_o` follows `host_cts_i`, and `gpio_oe` and `gpio_o` are 4'b0000.
- R3: A `bypass_cmd` pulse sampled high at a rising clock edge while in host routing puts the block in bypass routing from that edge on. Before that edge the outputs keep host routing.
- R4: In bypass routing, `gpio_o[0]` (PIO4) follows `host_rx_i` and `gpio_o[1]` (PIO5) follows `host_cts_i`, with `gpio_oe` = 4'b0011. `host_tx_o` follows `gpio_i[3]` (PIO7) and `host_rts_o` follows `gpio_i[2]` (PIO6), with both host output enables at 1.
- R5: In bypass routing, `core_rx_o` and `core_cts_o` are held at 1, and `core_tx_i` and `core_rts_i` have no effect on any pad.
- R6: `deep_sleep` rises at the same edge that enters bypass routing and stays at 1 until reset.
- R7: Once in bypass routing, further `bypass_cmd` pulses change nothing. Asserting `rst` ends bypass routing, and after `rst` is released the block is back in host routing with `deep_sleep` at 0.
- R8: A `bypass_cmd` pulse while `rst` is high is ignored: after release the block is in host routing with `deep_sleep` at 0.
- R9: `host_pull_up` is 4'b0011 at all times, including during reset. Bit 0 is TX (up), bit 1 is RTS (up), bit 2 is RX (down) and bit 3 is CTS (down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high asynchronous reset |
| bypass_cmd | input | 1 | Single-cycle request to enter bypass routing |
| core_tx_i | input | 1 | Internal UART transmit data |
| core_rts_i | input | 1 | Internal UART request-to-send |
| core_rx_o | output | 1 | Receive data delivered to internal UART |
| core_cts_o | output | 1 | Clear-to-send delivered to internal UART |
| host_tx_o | output | 1 | Host-side TX pad drive value |
| host_tx_oe | output | 1 | Host-side TX pad output enable |
| host_rts_o | output | 1 | Host-side RTS pad drive value |
| host_rts_oe | output | 1 | Host-side RTS pad output enable |
| host_rx_i | input | 1 | Host-side RX pad input |
| host_cts_i | input | 1 | Host-side CTS pad input |
| host_pull_up | output | 4 | Pull select per host pad, 1 = up, 0 = down |
| gpio_i | input | 4 | Spare pin inputs, bit 0 = PIO4 ... bit 3 = PIO7 |
| gpio_o | output | 4 | Spare pin drive values |
| gpio_oe | output | 4 | Spare pin output enables |
| deep_sleep | output | 1 | Deep-sleep indication, held while bypassed |

## Verification
The bench aims at the edge of bypass entry. It looks before and after the clock edge that samples the command, so a design that reroutes combinationally, or one cycle late, is caught. A command given during reset is probed, because a design that latched it would come out of reset asleep and bridged. Repeated commands in bypass and a reset taken in the middle of bypass show whether the mode is truly sticky and truly cleared. The core transmit lines keep toggling while bypassed, which exposes a mux that still lets them reach the pads or that stops holding the internal receive lines high.

// File: rtl/uart_byp_pkg.sv
package uart_byp_pkg;

    localparam int GPIO_W = 4;

    // spare pin slots (bit index within gpio_* vectors)
    localparam int SLOT_TX  = 0;   // PIO4, driven toward the second device
    localparam int SLOT_RTS = 1;   // PIO5, driven toward the second device
    localparam int SLOT_CTS = 2;   // PIO6, received from the second device
    localparam int SLOT_RX  = 3;   // PIO7, received from the second device

    localparam logic [GPIO_W-1:0] BYP_OE_MASK = GPIO_W'(1 << SLOT_TX) | GPIO_W'(1 << SLOT_RTS);

    typedef enum logic {
        ROUTE_HOST   = 1'b0,
        ROUTE_BYPASS = 1'b1
    } route_e;

    typedef struct packed {
        route_e route;
        logic   sleep;
    } ctrl_state_t;

endpackage

// File: rtl/uart_byp_ctrl.sv
module uart_byp_ctrl
    import uart_byp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bypass_cmd,
    output route_e route_o,
    output logic   sleep_o
);

    ctrl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (state_q.route == ROUTE_HOST && bypass_cmd) begin
            state_d.route = ROUTE_BYPASS;
            state_d.sleep = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= '{route: ROUTE_HOST, sleep: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign route_o = state_q.route;
    assign sleep_o = state_q.sleep;

    // R3: a command seen in host routing leads to bypass after the edge
    assert_enter_R3: assert property (@(posedge clk) disable iff (rst)
        (bypass_cmd && route_o == ROUTE_HOST) |=> (route_o == ROUTE_BYPASS));

    // R7: bypass never falls back without reset
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (route_o == ROUTE_BYPASS) |=> (route_o == ROUTE_BYPASS));

    // R6: sleep, once up, stays up
    assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (rst)
        sleep_o |=> sleep_o);

    // R6: sleep only rises on a command edge
    assert_sleep_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_o) |-> $past(bypass_cmd));

endmodule

// File: rtl/uart_byp_mux.sv
module uart_byp_mux
    import uart_byp_pkg::*;
(
    input  logic              rst,
    input  route_e            route_i,
    input  logic              core_tx_i,
    input  logic              core_rts_i,
    output logic              core_rx_o,
    output logic              core_cts_o,
    output logic              host_tx_o,
    output logic              host_tx_oe,
    output logic              host_rts_o,
    output logic              host_rts_oe,
    input  logic              host_rx_i,
    input  logic              host_cts_i,
    input  logic [GPIO_W-1:0] gpio_i,
    output logic [GPIO_W-1:0] gpio_o,
    output logic [GPIO_W-1:0] gpio_oe
);

    logic sel_host, sel_byp;

    always_comb begin
        sel_host = !rst && (route_i == ROUTE_HOST);
        sel_byp  = !rst && (route_i == ROUTE_BYPASS);

        // defaults: everything released, internal receivers idle
        core_rx_o   = 1'b1;
        core_cts_o  = 1'b1;
        host_tx_o   = 1'b0;
        host_tx_oe  = 1'b0;
        host_rts_o  = 1'b0;
        host_rts_oe = 1'b0;
        gpio_o      = '0;
        gpio_oe     = '0;

        if (sel_host) begin
            host_tx_o   = core_tx_i;
            host_tx_oe  = 1'b1;
            host_rts_o  = core_rts_i;
            host_rts_oe = 1'b1;
            core_rx_o   = host_rx_i;
            core_cts_o  = host_cts_i;
        end else if (sel_byp) begin
            // host pads bridged to the spare pins
            gpio_o[SLOT_TX]  = host_rx_i;
            gpio_o[SLOT_RTS] = host_cts_i;
            gpio_oe          = BYP_OE_MASK;
            host_tx_o        = gpio_i[SLOT_RX];
            host_tx_oe       = 1'b1;
            host_rts_o       = gpio_i[SLOT_CTS];
            host_rts_oe      = 1'b1;
        end
    end

    // R1: nothing driven while reset is held
    always_comb begin
        if (rst) begin
            assert_float_R1: assert (!host_tx_oe && !host_rts_oe && gpio_oe == '0);
        end
    end

    // R5: internal receivers see idle in bypass
    always_comb begin
        if (!rst && route_i == ROUTE_BYPASS) begin
            assert_idle_R5: assert (core_rx_o && core_cts_o);
        end
    end

    // R4: input-only spare slots are never driven
    always_comb begin
        if (!rst) begin
            assert_in_slots_R4: assert (!gpio_oe[SLOT_RX] && !gpio_oe[SLOT_CTS]);
        end
    end

endmodule

// File: rtl/uart_bypass_router.sv
module uart_bypass_router
    import uart_byp_pkg::*;
#(
    parameter logic [3:0] PULL_UP_MASK = 4'b0011
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass_cmd,
    input  logic              core_tx_i,
    input  logic              core_rts_i,
    output logic              core_rx_o,
    output logic              core_cts_o,
    output logic              host_tx_o,
    output logic              host_tx_oe,
    output logic              host_rts_o,
    output logic              host_rts_oe,
    input  logic              host_rx_i,
    input  logic              host_cts_i,
    output logic [3:0]        host_pull_up,
    input  logic [GPIO_W-1:0] gpio_i,
    output logic [GPIO_W-1:0] gpio_o,
    output logic [GPIO_W-1:0] gpio_oe,
    output logic              deep_sleep
);

    route_e route;
    logic   sleep;

    uart_byp_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bypass_cmd (bypass_cmd),
        .route_o    (route),
        .sleep_o    (sleep)
    );

    uart_byp_mux u_mux (
        .rst         (rst),
        .route_i     (route),
        .core_tx_i   (core_tx_i),
        .core_rts_i  (core_rts_i),
        .core_rx_o   (core_rx_o),
        .core_cts_o  (core_cts_o),
        .host_tx_o   (host_tx_o),
        .host_tx_oe  (host_tx_oe),
        .host_rts_o  (host_rts_o),
        .host_rts_oe (host_rts_oe),
        .host_rx_i   (host_rx_i),
        .host_cts_i  (host_cts_i),
        .gpio_i      (gpio_i),
        .gpio_o      (gpio_o),
        .gpio_oe     (gpio_oe)
    );

    assign host_pull_up = PULL_UP_MASK;
    assign deep_sleep   = sleep;

    // R6: sleep and bypass routing agree at the pins
    assert_sleep_pins_R6: assert property (@(posedge clk) disable iff (rst)
        deep_sleep |-> (gpio_oe != '0));

endmodule

// File: tb/sim_uart_bypass_router.sv
module sim_uart_bypass_router;

    localparam int PERIOD = 10;
    localparam int NVEC   = 6;

    // {in[7:0], exp_host[7:0], exp_byp[7:0]}
    // in  = {core_tx, core_rts, host_rx, host_cts, gpio_i[3:0]}
    // obs = {host_tx_o, host_rts_o, core_rx_o, core_cts_o, gpio_o[3:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'b1010_0110, 8'b1010_0000, 8'b0111_0001},
        {8'b0101_1001, 8'b0101_0000, 8'b1011_0010},
        {8'b1111_0000, 8'b1111_0000, 8'b0011_0011},
        {8'b0000_1111, 8'b0000_0000, 8'b1111_0000},
        {8'b1100_1100, 8'b1100_0000, 8'b1111_0000},
        {8'b0011_0011, 8'b0011_0000, 8'b0011_0011}
    };

    logic clk = 1'b0;
    logic rst, bypass_cmd, core_tx, core_rts, host_rx, host_cts;
    logic core_rx, core_cts, host_tx, host_tx_oe, host_rts, host_rts_oe, deep_sleep;
    logic [3:0] pull_up, gpio_in, gpio_out, gpio_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    uart_bypass_router u0 (
        .clk(clk), .rst(rst), .bypass_cmd(bypass_cmd),
        .core_tx_i(core_tx), .core_rts_i(core_rts),
        .core_rx_o(core_rx), .core_cts_o(core_cts),
        .host_tx_o(host_tx), .host_tx_oe(host_tx_oe),
        .host_rts_o(host_rts), .host_rts_oe(host_rts_oe),
        .host_rx_i(host_rx), .host_cts_i(host_cts),
        .host_pull_up(pull_up),
        .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe(gpio_oe),
        .deep_sleep(deep_sleep)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] v);
        {core_tx, core_rts, host_rx, host_cts, gpio_in} = v;
    endtask

    function automatic logic [7:0] obs();
        return {host_tx, host_rts, core_rx, core_cts, gpio_out};
    endfunction

    function automatic logic [6:0] oes();
        return {deep_sleep, host_tx_oe, host_rts_oe, gpio_oe};
    endfunction

    task automatic pulse_cmd();
        @(negedge clk); bypass_cmd = 1'b1;
        @(negedge clk); bypass_cmd = 1'b0;
    endtask

    initial begin
        rst = 1'b1; bypass_cmd = 1'b0; drive(8'hFF);
        repeat (2) @(negedge clk);
        #1;
        // R1 reset state: floats, no sleep, idle internal receivers
        chk("R1 oe/sleep in reset", 32'(oes()), 32'b000_0000);
        chk("R1 internal idle in reset", 32'({core_rx, core_cts}), 32'b11);
        chk("R9 pulls in reset", 32'(pull_up), 32'b0011);

        // R8 command while reset is high
        @(negedge clk); bypass_cmd = 1'b1;
        @(negedge clk); bypass_cmd = 1'b0; rst = 1'b0;
        @(negedge clk); #1;
        chk("R8 no sleep after ignored cmd", 32'(deep_sleep), 32'd0);
        chk("R8 host oe after ignored cmd", 32'(oes()), 32'b011_0000);

        // R2 host routing table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk); drive(VEC[i][23:16]); #1;
            chk("R2 host routing", 32'(obs()), 32'(VEC[i][15:8]));
            chk("R2 host enables", 32'(oes()), 32'b011_0000);
        end

        // R3 entry: not before the edge, bypass right after it
        @(negedge clk); bypass_cmd = 1'b1; drive(VEC[0][23:16]); #1;
        chk("R3 still host before edge", 32'(obs()), 32'(VEC[0][15:8]));
        @(negedge clk); bypass_cmd = 1'b0; #1;
        chk("R3 bypass after edge", 32'(obs()), 32'(VEC[0][7:0]));
        chk("R6 sleep with bypass", 32'(deep_sleep), 32'd1);

        // R4/R5 bypass table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk); drive(VEC[i][23:16]); #1;
            chk("R4 bypass routing", 32'(obs()), 32'(VEC[i][7:0]));
            chk("R4 bypass enables", 32'(oes()), 32'b111_0011);
        end
        // R5 core transmit lines toggled alone leave pads unchanged
        @(negedge clk); drive(8'b0000_0110); #1;
        chk("R5 core tx low", 32'(obs()), 32'b0111_0000);
        drive(8'b1100_0110); #1;
        chk("R5 core tx high no effect", 32'(obs()), 32'b0111_0000);
        chk("R9 pulls in bypass", 32'(pull_up), 32'b0011);

        // R7 extra command, long hold
        pulse_cmd();
        repeat (5) @(negedge clk);
        #1;
        chk("R7 sticky after extra cmd", 32'(oes()), 32'b111_0011);
        chk("R6 sleep held", 32'(deep_sleep), 32'd1);

        // R7 reset in the middle of bypass
        @(negedge clk); rst = 1'b1; #1;
        chk("R1 float on reset in bypass", 32'(oes()), 32'b000_0000);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); drive(VEC[1][23:16]); #1;
        chk("R7 host routing after reset", 32'(obs()), 32'(VEC[1][15:8]));
        chk("R7 sleep cleared", 32'(oes()), 32'b011_0000);
        chk("R9 pulls after reset", 32'(pull_up), 32'b0011);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule